// File: doc/BRIEF.md
# Three-Way Crossing Signal Controller

This block runs the signals at a junction where a highway, a railway line and a country road meet. It drives a three-valued lamp for each road and a single go/stop indication for the railway. Its inputs are a train-presence sensor, a sensor for vehicles waiting on the country road, and an indication that highway traffic is heavy.

The railway always wins. A train takes the crossing away from whichever road holds it. The road first shows amber and then red, and only then does the railway get GO. The highway owns the crossing by default. The country road is given a turn only when no train is present, the highway is not busy, and the highway has had its minimum green time. The country turn is bounded in length. Every hand-over from a green road passes through amber. After a train leaves, all lamps stay red for a clearance interval.

The three sensor inputs are asynchronous. Each is brought into the clock domain through a two-flop synchronizer. The block has no data stream, so all of its pins are plain level signals.

Top module: `xing_signal_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become highway green (`hwy_lamp` = 2'b10), country red (`ctry_lamp` = 2'b00) and railway stop (`rail_go` = 0). The lamp code is 2'b00 red, 2'b01 amber, 2'b10 green.
- R2: When a train is detected while a road is green, that road shows amber for exactly YELLOW_CYC cycles. `rail_go` then rises in the same cycle that the road turns red. `rail_go` never rises directly after a green lamp.
- R3: `rail_go` stays 1 for as long as the synchronized train input is 1. After the train input falls, all lamps are red and `rail_go` is 0 for CLEAR_CYC cycles, and then the highway turns green.
- R4: With no train, `ctry_in` high and `hwy_dense` low, a highway that has served its minimum green goes amber for YELLOW_CYC cycles. The country road then turns green while the highway is red.
- R5: While `hwy_dense` is high and no train is present, the highway stays green even if `ctry_in` is high.
- R6: Country green lasts exactly CTRY_MAX cycles if `ctry_in` stays high. It ends earlier once the synchronized `ctry_in` is 0. In both cases it is followed by country amber for YELLOW_CYC cycles and then highway green.
- R7: After highway green is entered, no country request is granted until the highway has been green for HWY_MIN cycles. With a request waiting, the highway green lasts exactly HWY_MIN cycles.
- R8: At every cycle at least one road lamp is red, and both road lamps are red whenever `rail_go` is 1.
- R9: A road lamp never goes from green straight to red. Every amber interval is exactly YELLOW_CYC cycles long, including amber caused by a train.
- R10: Each sensor passes through two synchronizer flops. A change on an input that is stable before clock edge k affects the lamps at edge k+2.
- R11: If a train is seen again during the all-red clearance, `rail_go` returns to 1 at the next edge, with no road lamp turning non-red in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_in | input | 1 | Train present at the crossing (asynchronous) |
| ctry_in | input | 1 | Vehicles waiting on the country road (asynchronous) |
| hwy_dense | input | 1 | Highway traffic is heavy (asynchronous) |
| hwy_lamp | output | 2 | Highway lamp: 00 red, 01 amber, 10 green |
| ctry_lamp | output | 2 | Country road lamp: 00 red, 01 amber, 10 green |
| rail_go | output | 1 | Railway signal: 1 go, 0 stop |

## Verification
The main collision is train preemption arriving in the same cycle as a road timing event. Such events are the country grant after the minimum highway green, the country maximum-green expiry, the end of an amber interval, or the end of clearance. The bench provokes these by toggling the train sensor at random against randomly changing country-request and density inputs. It also applies a directed one-cycle train drop that lands exactly on the clearance state. A cycle-accurate reference model in the bench, which includes its own synchronizer, judges every cycle. An independent check confirms that no two approaches are ever open at once.

// File: rtl/xing_pkg.sv
package xing_pkg;

  typedef enum logic [1:0] {
    LAMP_RED   = 2'b00,
    LAMP_AMBER = 2'b01,
    LAMP_GREEN = 2'b10
  } lamp_t;

  typedef enum logic [2:0] {
    PH_HWY_GO,
    PH_HWY_AMBER,
    PH_CTRY_GO,
    PH_CTRY_AMBER,
    PH_RAIL_GO,
    PH_CLEAR
  } phase_t;

endpackage

// File: rtl/xing_sync.sv
module xing_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/xing_timer.sv
module xing_timer #(
  parameter int LIMIT = 8,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  // Counts cycles spent in the current phase; sticks at TOP.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (count != TOP) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/xing_phase_fsm.sv
module xing_phase_fsm
  import xing_pkg::*;
#(
  parameter int YELLOW_CYC = 3,
  parameter int CLEAR_CYC  = 2,
  parameter int CTRY_MAX   = 8,
  parameter int HWY_MIN    = 8,
  parameter int CW         = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          train_s,
  input  logic          ctry_s,
  input  logic          dense_s,
  input  logic [CW-1:0] elapsed,
  output phase_t        phase,
  output logic          restart
);

  localparam logic [CW-1:0] AMB_LAST  = CW'(YELLOW_CYC - 1);
  localparam logic [CW-1:0] CLR_LAST  = CW'(CLEAR_CYC - 1);
  localparam logic [CW-1:0] CTRY_LAST = CW'(CTRY_MAX - 1);
  localparam logic [CW-1:0] HWY_LAST  = CW'(HWY_MIN - 1);

  phase_t nxt;
  logic   to_ctry, to_ctry_nxt;

  always_comb begin
    nxt         = phase;
    to_ctry_nxt = to_ctry;
    case (phase)
      PH_HWY_GO: begin
        if (train_s) begin
          nxt         = PH_HWY_AMBER;
          to_ctry_nxt = 1'b0;
        end else if (ctry_s && !dense_s && elapsed >= HWY_LAST) begin
          nxt         = PH_HWY_AMBER;
          to_ctry_nxt = 1'b1;
        end
      end
      PH_HWY_AMBER: begin
        if (elapsed == AMB_LAST) begin
          if (train_s)      nxt = PH_RAIL_GO;
          else if (to_ctry) nxt = PH_CTRY_GO;
          else              nxt = PH_CLEAR;
        end
      end
      PH_CTRY_GO: begin
        if (train_s || !ctry_s || elapsed == CTRY_LAST) nxt = PH_CTRY_AMBER;
      end
      PH_CTRY_AMBER: begin
        if (elapsed == AMB_LAST) nxt = train_s ? PH_RAIL_GO : PH_HWY_GO;
      end
      PH_RAIL_GO: begin
        if (!train_s) nxt = PH_CLEAR;
      end
      PH_CLEAR: begin
        if (train_s)                    nxt = PH_RAIL_GO;
        else if (elapsed == CLR_LAST)   nxt = PH_HWY_GO;
      end
      default: nxt = PH_HWY_GO;
    endcase
  end

  assign restart = (nxt != phase);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_HWY_GO;
      to_ctry <= 1'b0;
    end else begin
      phase   <= nxt;
      to_ctry <= to_ctry_nxt;
    end
  end

  // R5: heavy highway traffic keeps the highway in charge
  a_r5_dense_holds_hwy: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HWY_GO && dense_s && !train_s) |=> (phase == PH_HWY_GO));

  // R3: railway stays open while the train is seen
  a_r3_rail_held: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RAIL_GO && train_s) |=> (phase == PH_RAIL_GO));

  // R11: train re-seen during clearance reopens the railway at once
  a_r11_clear_reopen: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CLEAR && train_s) |=> (phase == PH_RAIL_GO));

endmodule

// File: rtl/xing_lamp_decode.sv
module xing_lamp_decode
  import xing_pkg::*;
#(
  parameter int YELLOW_CYC = 3
) (
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase,
  output lamp_t  hwy_o,
  output lamp_t  ctry_o,
  output logic   rail_o
);

  localparam int RW = $clog2(YELLOW_CYC + 2);

  always_comb begin
    hwy_o  = LAMP_RED;
    ctry_o = LAMP_RED;
    rail_o = 1'b0;
    case (phase)
      PH_HWY_GO:     hwy_o  = LAMP_GREEN;
      PH_HWY_AMBER:  hwy_o  = LAMP_AMBER;
      PH_CTRY_GO:    ctry_o = LAMP_GREEN;
      PH_CTRY_AMBER: ctry_o = LAMP_AMBER;
      PH_RAIL_GO:    rail_o = 1'b1;
      default: ;
    endcase
  end

  // Amber run lengths, watched by the R9 checks below
  logic [RW-1:0] hwy_amb_run, ctry_amb_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hwy_amb_run  <= '0;
      ctry_amb_run <= '0;
    end else begin
      hwy_amb_run  <= (hwy_o  == LAMP_AMBER) ? hwy_amb_run  + 1'b1 : '0;
      ctry_amb_run <= (ctry_o == LAMP_AMBER) ? ctry_amb_run + 1'b1 : '0;
    end
  end

  a_r8_roads_exclusive: assert property (@(posedge clk) disable iff (rst)
    (hwy_o == LAMP_RED) || (ctry_o == LAMP_RED));

  a_r8_rail_roads_red: assert property (@(posedge clk) disable iff (rst)
    rail_o |-> (hwy_o == LAMP_RED && ctry_o == LAMP_RED));

  a_r9_hwy_no_skip: assert property (@(posedge clk) disable iff (rst)
    ($past(hwy_o) == LAMP_GREEN && hwy_o != LAMP_GREEN) |-> (hwy_o == LAMP_AMBER));

  a_r9_ctry_no_skip: assert property (@(posedge clk) disable iff (rst)
    ($past(ctry_o) == LAMP_GREEN && ctry_o != LAMP_GREEN) |-> (ctry_o == LAMP_AMBER));

  a_r9_hwy_amber_len: assert property (@(posedge clk) disable iff (rst)
    (hwy_o != LAMP_AMBER && hwy_amb_run != 0) |-> (hwy_amb_run == RW'(YELLOW_CYC)));

  a_r9_ctry_amber_len: assert property (@(posedge clk) disable iff (rst)
    (ctry_o != LAMP_AMBER && ctry_amb_run != 0) |-> (ctry_amb_run == RW'(YELLOW_CYC)));

  // R2: the railway never opens straight after a green road
  a_r2_rail_after_red: assert property (@(posedge clk) disable iff (rst)
    $rose(rail_o) |-> ($past(hwy_o) != LAMP_GREEN && $past(ctry_o) != LAMP_GREEN));

endmodule

// File: rtl/xing_signal_ctrl.sv
module xing_signal_ctrl
  import xing_pkg::*;
#(
  parameter int YELLOW_CYC  = 3,
  parameter int CLEAR_CYC   = 2,
  parameter int CTRY_MAX    = 8,
  parameter int HWY_MIN     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       train_in,
  input  logic       ctry_in,
  input  logic       hwy_dense,
  output logic [1:0] hwy_lamp,
  output logic [1:0] ctry_lamp,
  output logic       rail_go
);

  localparam int LIM_A   = (YELLOW_CYC > CLEAR_CYC) ? YELLOW_CYC : CLEAR_CYC;
  localparam int LIM_B   = (CTRY_MAX > HWY_MIN) ? CTRY_MAX : HWY_MIN;
  localparam int T_LIMIT = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int CW      = $clog2(T_LIMIT + 1);

  logic [2:0]    sens_s;
  logic [CW-1:0] elapsed;
  logic          restart;
  phase_t        phase;
  lamp_t         hwy_l, ctry_l;

  xing_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({train_in, ctry_in, hwy_dense}),
    .q   (sens_s)
  );

  xing_timer #(.LIMIT(T_LIMIT), .CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (restart),
    .count (elapsed)
  );

  xing_phase_fsm #(
    .YELLOW_CYC (YELLOW_CYC),
    .CLEAR_CYC  (CLEAR_CYC),
    .CTRY_MAX   (CTRY_MAX),
    .HWY_MIN    (HWY_MIN),
    .CW         (CW)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .train_s (sens_s[2]),
    .ctry_s  (sens_s[1]),
    .dense_s (sens_s[0]),
    .elapsed (elapsed),
    .phase   (phase),
    .restart (restart)
  );

  xing_lamp_decode #(.YELLOW_CYC(YELLOW_CYC)) u_lamps (
    .clk    (clk),
    .rst    (rst),
    .phase  (phase),
    .hwy_o  (hwy_l),
    .ctry_o (ctry_l),
    .rail_o (rail_go)
  );

  assign hwy_lamp  = hwy_l;
  assign ctry_lamp = ctry_l;

endmodule

// File: tb/xing_signal_ctrl_tb.sv
module xing_signal_ctrl_tb;

  localparam int YEL = 3, CLR = 2, CMAX = 8, HMIN = 8, LIM = 8;
  localparam int P_HG = 0, P_HA = 1, P_CG = 2, P_CA = 3, P_RG = 4, P_CL = 5;
  localparam logic [1:0] RED = 2'b00, AMB = 2'b01, GRN = 2'b10;

  logic clk = 1'b0, rst = 1'b1;
  logic y = 1'b0, x = 1'b0, d = 1'b0;
  logic [1:0] hwy_lamp, ctry_lamp;
  logic rail_go;
  int checks = 0, errors = 0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  xing_signal_ctrl u_dut (
    .clk(clk), .rst(rst), .train_in(y), .ctry_in(x), .hwy_dense(d),
    .hwy_lamp(hwy_lamp), .ctry_lamp(ctry_lamp), .rail_go(rail_go)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model built from the requirements
  logic [2:0] m_s1 = '0, m_s2 = '0;
  int m_ph = P_HG, m_cnt = 0;
  bit m_toc = 1'b0;

  always @(posedge clk) begin
    int  nph;
    bit  ntoc, tr, cr, dn;
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_ph <= P_HG; m_cnt <= 0; m_toc <= 1'b0;
    end else begin
      tr = m_s2[2]; cr = m_s2[1]; dn = m_s2[0];
      nph = m_ph; ntoc = m_toc;
      case (m_ph)
        P_HG: if (tr) begin nph = P_HA; ntoc = 0; end
              else if (cr && !dn && m_cnt >= HMIN-1) begin nph = P_HA; ntoc = 1; end
        P_HA: if (m_cnt == YEL-1) nph = tr ? P_RG : (m_toc ? P_CG : P_CL);
        P_CG: if (tr || !cr || m_cnt == CMAX-1) nph = P_CA;
        P_CA: if (m_cnt == YEL-1) nph = tr ? P_RG : P_HG;
        P_RG: if (!tr) nph = P_CL;
        default: if (tr) nph = P_RG; else if (m_cnt == CLR-1) nph = P_HG;
      endcase
      m_s1 <= {y, x, d};
      m_s2 <= m_s1;
      if (nph != m_ph) m_cnt <= 0;
      else if (m_cnt < LIM) m_cnt <= m_cnt + 1;
      m_ph <= nph; m_toc <= ntoc;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      int eh, ec, er;
      eh = (m_ph == P_HG) ? GRN : (m_ph == P_HA) ? AMB : RED;
      ec = (m_ph == P_CG) ? GRN : (m_ph == P_CA) ? AMB : RED;
      er = (m_ph == P_RG) ? 1 : 0;
      chk(hwy_lamp == eh[1:0], "R2 R4 R5 R7 R9 R10 hwy_lamp vs model", hwy_lamp, eh);
      chk(ctry_lamp == ec[1:0], "R4 R6 R9 ctry_lamp vs model", ctry_lamp, ec);
      chk(rail_go == er[0], "R3 R11 rail_go vs model", rail_go, er);
      chk(hwy_lamp == RED || ctry_lamp == RED, "R8 both roads open", ctry_lamp, 0);
      chk(!rail_go || (hwy_lamp == RED && ctry_lamp == RED), "R8 road open with rail go",
          hwy_lamp, 0);
    end
  end

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h1A2B3C4D));
    repeat (4) @(negedge clk);
    chk(hwy_lamp == GRN, "R1 reset hwy green", hwy_lamp, GRN);
    chk(ctry_lamp == RED, "R1 reset ctry red", ctry_lamp, RED);
    chk(rail_go == 1'b0, "R1 reset rail stop", rail_go, 0);
    rst = 1'b0;
    model_on = 1'b1;
    repeat (12) @(negedge clk);

    // R10 / R2: synchronizer latency and preemption through amber
    y = 1'b1;
    @(negedge clk); chk(hwy_lamp == GRN, "R10 still green after 1 edge", hwy_lamp, GRN);
    @(negedge clk); chk(hwy_lamp == GRN, "R10 still green after 2 edges", hwy_lamp, GRN);
    @(negedge clk); chk(hwy_lamp == AMB, "R10 amber after 3 edges", hwy_lamp, AMB);
    repeat (2) @(negedge clk);
    chk(hwy_lamp == AMB, "R2 amber held", hwy_lamp, AMB);
    @(negedge clk);
    chk(rail_go == 1'b1, "R2 rail go after amber", rail_go, 1);
    chk(hwy_lamp == RED, "R2 hwy red under rail", hwy_lamp, RED);
    repeat (5) @(negedge clk);
    chk(rail_go == 1'b1, "R3 rail held with train", rail_go, 1);

    // R11: one-cycle train drop lands on clearance
    y = 1'b0; @(negedge clk);
    y = 1'b1; @(negedge clk);
    @(negedge clk);
    chk(rail_go == 1'b0 && hwy_lamp == RED && ctry_lamp == RED, "R11 clearance entered",
        rail_go, 0);
    @(negedge clk);
    chk(rail_go == 1'b1, "R11 rail reopened from clearance", rail_go, 1);
    repeat (3) @(negedge clk);

    // R3: clearance after train leaves
    y = 1'b0;
    repeat (3) @(negedge clk);
    chk(rail_go == 1'b0 && hwy_lamp == RED, "R3 clearance first cycle", rail_go, 0);
    @(negedge clk);
    chk(hwy_lamp == RED && ctry_lamp == RED, "R3 clearance second cycle", hwy_lamp, RED);
    @(negedge clk);
    chk(hwy_lamp == GRN, "R3 highway green after clearance", hwy_lamp, GRN);

    // R5: heavy highway blocks the country request
    d = 1'b1; x = 1'b1;
    repeat (30) @(negedge clk);
    chk(hwy_lamp == GRN && ctry_lamp == RED, "R5 dense keeps highway", hwy_lamp, GRN);

    // R4 / R6 / R7: full country turn with request held
    d = 1'b0;
    n = 0;
    while (ctry_lamp != GRN && n < 40) begin n++; @(negedge clk); end
    chk(hwy_lamp == RED && ctry_lamp == GRN, "R4 country granted", ctry_lamp, GRN);
    n = 0;
    while (ctry_lamp == GRN && n < 50) begin n++; @(negedge clk); end
    chk(n == CMAX, "R6 country max green length", n, CMAX);
    n = 0;
    while (hwy_lamp != GRN && n < 50) begin n++; @(negedge clk); end
    chk(n == YEL, "R6 country amber then highway", n, YEL);
    n = 0;
    while (hwy_lamp == GRN && n < 50) begin n++; @(negedge clk); end
    chk(n == HMIN, "R7 minimum highway green", n, HMIN);

    // R6: early end when the request goes away
    n = 0;
    while (ctry_lamp != GRN && n < 40) begin n++; @(negedge clk); end
    x = 1'b0;
    n = 0;
    while (ctry_lamp == GRN && n < 50) begin n++; @(negedge clk); end
    chk(n == 3, "R6 early end of country green", n, 3);

    // Random traffic, trains colliding with road timing events
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom % 40 == 0) y = ~y;
      if ($urandom % 6 == 0)  x = 1'($urandom % 2);
      if ($urandom % 12 == 0) d = 1'($urandom % 3 == 0);
    end
    y = 1'b0;
    repeat (20) @(negedge clk);
    chk(rail_go == 1'b0 && hwy_lamp != RED || ctry_lamp != RED, "R3 settles after trains",
        rail_go, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule